// File: doc/BRIEF.md
# Double-Length Bit-Serial Shift Unit

This block moves a 64-bit pair made of an accumulator word (upper half) and a second register word (lower half) by one bit position per clock. There are two commands. A left command rotates the whole pair. A right command shifts the pair arithmetically, so the sign bit of the accumulator is copied into the vacated positions.

The shift amount arrives as a 6-bit count field, and the unit never loads the amount as a plain number. It loads the field into a step counter and adds one to that counter on every step. The run stops when the counter wraps from 63 to zero. For a right shift of n places the caller therefore supplies 64 − n, and for a left rotate of n places the caller supplies n. Inside the unit, every step is the same right move of the pair:

- the low bit of the accumulator goes into the top of the register word;
- on a rotate, the bit leaving the register word re-enters at the top of the accumulator.

Taking 64 − n such steps gives a rotate left by n.

When the run ends, the unit raises a one-cycle completion pulse. Together with it, it reports how many word periods the caller must still wait after the operation. That figure depends only on the top bit of the count field.

Top module: `dls_shift_unit`

## Requirements
- R1: After reset, `busy` and `done` are low, `acc_out` and `reg_out` are zero, and `post_wait` is zero.
- R2: With `rot_left` = 0 and count field c ≠ 0, the final `{acc_out, reg_out}` equals `{acc_in, reg_in}` shifted right arithmetically by 64 − c places, with bit 31 of the accumulator copied in.
- R3: With `rot_left` = 1 and count field c ≠ 0, the final `{acc_out, reg_out}` equals `{acc_in, reg_in}` rotated left by c places.
- R4: A count field of zero performs no movement. The loaded operands appear unchanged with `done` on the next cycle, and `busy` never rises.
- R5: For c ≠ 0, `busy` is high for exactly 64 − c cycles. `done` rises on the first cycle after the last step, which is 1 + (64 − c) cycles after the cycle in which `start` is sampled.
- R6: `post_wait` is loaded when a command is accepted. It equals 1 when bit 5 of the count field is 1, and 2 when bit 5 is 0. It holds that value until the next command is accepted.
- R7: While `busy` is high, `start` and the operand, direction and count inputs are ignored. The running operation finishes with its original result and timing.
- R8: `done` is high for one cycle per accepted command and is never high while `busy` is high.
- R9: During a right-shift step, bit 31 of the accumulator keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command request, accepted when not busy |
| rot_left | input | 1 | 1 = rotate pair left, 0 = arithmetic right shift |
| count_fld | input | 6 | Encoded count: n for left, 64 − n for right |
| acc_in | input | 32 | Accumulator operand (upper half of pair) |
| reg_in | input | 32 | Register operand (lower half of pair) |
| acc_out | output | 32 | Current accumulator half |
| reg_out | output | 32 | Current register half |
| busy | output | 1 | Stepping in progress |
| done | output | 1 | One-cycle completion pulse |
| post_wait | output | 2 | Word periods to charge after the operation |

## Verification
The assertions assume `start` is a clean synchronous level. They also assume that the inputs accepted with it are settled on that same edge, because the counter and the operand registers load them there without any check. The bench drives every input on the falling edge, so each command is stable long before the rising edge that samples it.

The random operands use the full 32-bit range, and the random counts use the full 6-bit range, including zero. Directed cases add the extremes: counts 1, 32 and 63 in both directions, and a second `start` raised in the middle of a run.

// File: rtl/dls_pkg.sv
package dls_pkg;
   typedef enum logic {
      MOVE_RIGHT_ARITH = 1'b0,
      MOVE_ROT_LEFT    = 1'b1
   } move_kind_e;
endpackage

// File: rtl/dls_wrap_counter.sv
module dls_wrap_counter #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_width
      $error("dls_wrap_counter: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (step)
         cnt <= cnt + 1'b1;
   end

   assign last = (cnt == TOP);

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/dls_pair_path.sv
module dls_pair_path #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] acc_ld,
   input  logic [WORD_W-1:0] reg_ld,
   input  logic              step,
   input  dls_pkg::move_kind_e kind,
   output logic [WORD_W-1:0] acc_q,
   output logic [WORD_W-1:0] reg_q
);
   import dls_pkg::*;

   logic fill_bit;
   logic [WORD_W-1:0] acc_nx, reg_nx;

   if (WORD_W < 2) begin : g_bad_word
      $error("dls_pair_path: WORD_W must be at least 2");
   end

   always_comb begin
      fill_bit = (kind == MOVE_ROT_LEFT) ? reg_q[0] : acc_q[WORD_W-1];
      acc_nx   = {fill_bit, acc_q[WORD_W-1:1]};
      reg_nx   = {acc_q[0], reg_q[WORD_W-1:1]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         reg_q <= '0;
      end else if (load) begin
         acc_q <= acc_ld;
         reg_q <= reg_ld;
      end else if (step) begin
         acc_q <= acc_nx;
         reg_q <= reg_nx;
      end
   end

   // R9
   sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && kind == MOVE_RIGHT_ARITH) |=> (acc_q[WORD_W-1] == $past(acc_q[WORD_W-1])));

   // R2
   low_bit_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> (reg_q[WORD_W-1] == $past(acc_q[0])));
endmodule

// File: rtl/dls_wait_calc.sv
module dls_wait_calc #(
   parameter int CNT_W      = 6,
   parameter int SHORT_WAIT = 1,
   parameter int LONG_WAIT  = 2,
   localparam int WAIT_W    = $clog2(LONG_WAIT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CNT_W-1:0]  field,
   output logic [WAIT_W-1:0] wait_q
);
   localparam logic [WAIT_W-1:0] SHORT_V = WAIT_W'(SHORT_WAIT);
   localparam logic [WAIT_W-1:0] LONG_V  = WAIT_W'(LONG_WAIT);

   if (SHORT_WAIT > LONG_WAIT) begin : g_bad_wait
      $error("dls_wait_calc: SHORT_WAIT must not exceed LONG_WAIT");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wait_q <= '0;
      else if (load)
         wait_q <= field[CNT_W-1] ? SHORT_V : LONG_V;
   end

   // R6
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(wait_q));
endmodule

// File: rtl/dls_shift_unit.sv
module dls_shift_unit #(
   parameter int WORD_W     = 32,
   parameter int SHORT_WAIT = 1,
   parameter int LONG_WAIT  = 2,
   localparam int PAIR_W    = 2 * WORD_W,
   localparam int CNT_W     = $clog2(PAIR_W),
   localparam int WAIT_W    = $clog2(LONG_WAIT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              rot_left,
   input  logic [CNT_W-1:0]  count_fld,
   input  logic [WORD_W-1:0] acc_in,
   input  logic [WORD_W-1:0] reg_in,
   output logic [WORD_W-1:0] acc_out,
   output logic [WORD_W-1:0] reg_out,
   output logic              busy,
   output logic              done,
   output logic [WAIT_W-1:0] post_wait
);
   import dls_pkg::*;

   if ((WORD_W & (WORD_W - 1)) != 0) begin : g_bad_pow2
      $error("dls_shift_unit: WORD_W must be a power of two");
   end

   logic       busy_q, done_q, accept, last;
   move_kind_e kind_q;
   logic [CNT_W-1:0] cnt;

   assign accept = start && !busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         kind_q <= MOVE_RIGHT_ARITH;
      end else if (accept) begin
         busy_q <= (count_fld != '0);
         done_q <= (count_fld == '0);
         kind_q <= rot_left ? MOVE_ROT_LEFT : MOVE_RIGHT_ARITH;
      end else begin
         busy_q <= busy_q && !last;
         done_q <= busy_q && last;
      end
   end

   dls_wrap_counter #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(count_fld),
      .step(busy_q), .cnt(cnt), .last(last));

   dls_pair_path #(.WORD_W(WORD_W)) u_pair (
      .clk(clk), .rst_n(rst_n), .load(accept), .acc_ld(acc_in),
      .reg_ld(reg_in), .step(busy_q), .kind(kind_q),
      .acc_q(acc_out), .reg_q(reg_out));

   dls_wait_calc #(.CNT_W(CNT_W), .SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)) u_wait (
      .clk(clk), .rst_n(rst_n), .load(accept), .field(count_fld),
      .wait_q(post_wait));

   assign busy = busy_q;
   assign done = done_q;

   // R8
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_q && done_q));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q || $past(accept));

   // R7
   ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start) |=> $stable(kind_q));

   // R4
   zero_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && count_fld == '0) |=> (!busy_q && done_q));

   // R6
   wait_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (post_wait == WAIT_W'(SHORT_WAIT) || post_wait == WAIT_W'(LONG_WAIT)));
endmodule

// File: tb/dls_shift_unit_tb.sv
module dls_shift_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rot_left = 1'b0;
   logic [5:0]  count_fld = '0;
   logic [31:0] acc_in = '0, reg_in = '0;
   logic [31:0] acc_out, reg_out;
   logic        busy, done;
   logic [1:0]  post_wait;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   dls_shift_unit u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .rot_left(rot_left),
      .count_fld(count_fld), .acc_in(acc_in), .reg_in(reg_in),
      .acc_out(acc_out), .reg_out(reg_out), .busy(busy), .done(done),
      .post_wait(post_wait));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   function automatic logic [63:0] exp_pair(bit left, logic [5:0] c, logic [63:0] p);
      int n;
      if (c == 0) return p;
      if (left) begin
         n = c;
         return (p << n) | (p >> (64 - n));
      end
      n = 64 - int'(c);
      return 64'($signed(p) >>> n);
   endfunction

   function automatic int exp_steps(logic [5:0] c);
      return (c == 0) ? 0 : 64 - int'(c);
   endfunction

   task automatic chk64(string req, logic [63:0] act, logic [63:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_int(string req, int act, int exp);
      checks = checks + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_op(bit left, logic [5:0] c, logic [31:0] a, logic [31:0] r, bit disturb);
      int lat;
      int busy_cycles;
      string res_req;
      res_req = left ? "R3 rotate result" : "R2 arithmetic result";
      if (c == 0) res_req = "R4 zero field result";
      @(negedge clk);
      rot_left = left; count_fld = c; acc_in = a; reg_in = r; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      busy_cycles = 0;
      while (!done && lat < 200) begin
         if (busy) busy_cycles++;
         if (disturb && lat == 3) begin
            // R7: second start while busy must be ignored
            rot_left = ~left; count_fld = 6'd1; acc_in = ~a; reg_in = ~r; start = 1'b1;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      chk64(res_req, {acc_out, reg_out}, exp_pair(left, c, {a, r}));
      chk_int(disturb ? "R7 latency with ignored start" : "R5 done latency", lat, 1 + exp_steps(c));
      chk_int("R5 busy cycles", busy_cycles, exp_steps(c));
      chk_int("R6 post wait", int'(post_wait), c[5] ? 1 : 2);
      chk_int("R8 busy low with done", int'(busy), 0);
      @(negedge clk);
      chk_int("R8 done single pulse", int'(done), 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_int("R1 busy at reset", int'(busy), 0);
      chk_int("R1 done at reset", int'(done), 0);
      chk64("R1 pair at reset", {acc_out, reg_out}, 64'd0);
      chk_int("R1 wait at reset", int'(post_wait), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      run_op(1'b0, 6'd0,  32'h8000_0001, 32'h1234_5678, 1'b0); // R4
      run_op(1'b1, 6'd0,  32'hDEAD_BEEF, 32'h0000_0001, 1'b0); // R4
      run_op(1'b0, 6'd63, 32'h8000_0000, 32'h0000_0003, 1'b0); // R2 n=1
      run_op(1'b0, 6'd1,  32'h8000_0000, 32'h0000_0000, 1'b0); // R2 n=63
      run_op(1'b0, 6'd32, 32'hF000_000F, 32'hAAAA_5555, 1'b0); // R2 n=32, R6
      run_op(1'b0, 6'd40, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0); // R2 positive
      run_op(1'b1, 6'd1,  32'h8000_0000, 32'h0000_0001, 1'b0); // R3 n=1
      run_op(1'b1, 6'd63, 32'h0000_0001, 32'h8000_0000, 1'b0); // R3 n=63
      run_op(1'b1, 6'd32, 32'h0123_4567, 32'h89AB_CDEF, 1'b0); // R3 swap
      run_op(1'b0, 6'd20, 32'hC3C3_0F0F, 32'h1111_2222, 1'b1); // R7
      run_op(1'b1, 6'd10, 32'h5A5A_A5A5, 32'h0F0F_F0F0, 1'b1); // R7

      // random mix
      for (int k = 0; k < 60; k++) begin
         run_op(1'($urandom), 6'($urandom), $urandom, $urandom, (k % 7) == 3);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule